// File: doc/BRIEF.md
# Interrupt status, mask and coalescing unit

This unit gathers interrupt events and presents them to a host. Some events come from internal sources. The rest come from a set of DMA flow channels, and those are recorded in a secondary flow status register. Each event pulse latches a bit in its status register. The bit stays set until the host writes a 1 to that bit position. Three bits of the main status word are summaries: each one is the OR of a group of flow bits. Writing a 1 to a summary bit clears the whole group behind it.

An enable mask picks which main status bits may raise the single host interrupt line. A programmable coalescing interval holds the line back after the first enabled event, so that several events can be serviced in one go. The interval is counted in units of 32 microseconds. A prescaler of `TICK_CYCLES` clock cycles produces each unit. A high-priority receive event on the flow register skips the wait, and so does an interval of zero. Register access is a simple select/write-strobe/read-mux port. Any bus protocol is added outside.

Top module: `irq_coalescing_ctrl`

## Requirements
- R1: After reset, the main and flow status registers read 0, the interval register reads 0, the enable mask reads 0xAA00008B (bits 31, 29, 27, 25, 7, 3, 1, 0) and the interrupt line is low. Register select encoding: 0 main status, 1 enable mask, 2 flow status, 3 interval (low `CW` bits, upper bits read 0).
- R2: An event pulse sets its status bit, and the bit holds until the host writes 1 to it. Writing 0 to a status bit leaves it unchanged.
- R3: When an event and a host write-1 clear hit the same bit in the same cycle, the bit stays set.
- R4: Main bit 31 reads as the OR of flow bits 30, 17 and 16. Main bit 29 reads as flow bit 31. Main bit 27 reads as the OR of flow bits 1 and 0. Writing 1 to one of these main bits clears every flow bit in its group and leaves the other flow bits alone.
- R5: The main register stores events only at bits 28, 26, 25, 7, 6, 3, 1 and 0. The flow register stores events only at bits 31, 30, 17, 16, 1 and 0. Events at any other position are ignored and read as 0.
- R6: The interrupt line responds only to main status bits that are enabled in the mask. Enabling a bit that is already pending raises the line.
- R7: With an interval of 0, the line rises on the first clock edge after the edge at which the status bit is set.
- R8: With an interval of N > 0, the line rises N*TICK_CYCLES+2 edges after the edge that samples the first enabled event. Later events during the wait do not restart it.
- R9: A pending flow bit 30 with mask bit 31 set raises the line on the next edge. This holds whether the unit is idle or partway through a coalescing wait.
- R10: The line falls on the first edge after no enabled status bit remains pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_evt_i | input | 32 | Event pulses for the direct main status bits |
| flow_evt_i | input | 32 | Event pulses for the flow status bits |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for writes |
| wr_data_i | input | 32 | Write data (write-1-to-clear for status registers) |
| rd_sel_i | input | 2 | Register select for reads |
| rd_data_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Host interrupt line |

## Verification
A vector table drives single flow bits, all-ones patterns and unimplemented positions, and reads back both status words. This separates a summary bit that is wired to the wrong group from one that latches a stray position. The latency of the line is measured in edges for three cases: an interval of 0, an interval of 3 with a second event in the middle of the wait, and an interval of 5 with a high-priority event injected partway through. Each case has its own expected count, so an off-by-one error in the prescaler, a timer that restarts, and a missing bypass all show up as different numbers. Separate directed steps cover a clear and an event colliding on the same bit, group clears issued through the main register, and a mask change while a bit is already pending.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned REG_W = 32;

  typedef enum logic [1:0] {
    SEL_MAIN = 2'd0,
    SEL_MASK = 2'd1,
    SEL_FLOW = 2'd2,
    SEL_INTV = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    CO_IDLE = 2'd0,
    CO_WAIT = 2'd1,
    CO_FIRE = 2'd2
  } co_state_e;

  // main bits that latch their own events
  localparam logic [REG_W-1:0] MAIN_DIRECT_BITS = 32'h1600_00CB;
  // flow bits that exist
  localparam logic [REG_W-1:0] FLOW_IMPL_BITS   = 32'hC003_0003;
  localparam logic [REG_W-1:0] MASK_RESET_VAL   = 32'hAA00_008B;

  localparam int unsigned NUM_GRP = 3;
  localparam int unsigned HP_FLOW_POS = 30;
  localparam int unsigned HP_MASK_POS = 31;

  // summary group: main bit position and the flow bits it covers
  function automatic int unsigned grp_pos(input int unsigned g);
    case (g)
      0:       grp_pos = 31;
      1:       grp_pos = 29;
      default: grp_pos = 27;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] grp_mask(input int unsigned g);
    case (g)
      0:       grp_mask = 32'h4003_0000;
      1:       grp_mask = 32'h8000_0000;
      default: grp_mask = 32'h0000_0003;
    endcase
  endfunction

endpackage

// File: rtl/irqc_w1c_reg.sv
module irqc_w1c_reg #(
  parameter int unsigned     W    = 32,
  parameter logic [W-1:0]    IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] set_m, clr_m, q_d, q_q;
  logic         q_en;

  always_comb begin
    set_m = set_i & IMPL;
    clr_m = clr_i & IMPL;
    q_en  = |(set_m | clr_m);
    // set has priority over a clear of the same bit
    q_d   = (q_q & ~clr_m) | set_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= '0;
    else if (q_en) q_q <= q_d;
  end

  assign q_o = q_q;

  p_evt_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_m) |=> ((q_q & $past(set_m)) == $past(set_m)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|set_m) && !(|clr_m)) |=> $stable(q_q));

  p_impl_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((q_q & ~IMPL) == '0));

endmodule

// File: rtl/irqc_coalesce.sv
module irqc_coalesce
  import irqc_pkg::*;
#(
  parameter int unsigned CW          = 8,
  parameter int unsigned TICK_CYCLES = 6400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pend_i,
  input  logic          hp_i,
  input  logic [CW-1:0] intv_i,
  output logic          irq_o
);

  localparam int unsigned PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  co_state_e        st_q, st_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CW-1:0]    unit_q, unit_d;
  logic             cnt_en;

  always_comb begin
    st_d   = st_q;
    pre_d  = pre_q;
    unit_d = unit_q;
    unique case (st_q)
      CO_IDLE: begin
        if (pend_i) begin
          if (hp_i || (intv_i == '0)) begin
            st_d = CO_FIRE;
          end else begin
            st_d   = CO_WAIT;
            pre_d  = '0;
            unit_d = '0;
          end
        end
      end
      CO_WAIT: begin
        if (!pend_i) begin
          st_d = CO_IDLE;
        end else if (hp_i || (unit_q >= intv_i)) begin
          st_d = CO_FIRE;
        end else if (pre_q == PRE_LAST) begin
          pre_d  = '0;
          unit_d = unit_q + 1'b1;
        end else begin
          pre_d = pre_q + 1'b1;
        end
      end
      default: begin
        if (!pend_i) st_d = CO_IDLE;
      end
    endcase
    cnt_en = (st_q == CO_WAIT) || (st_d == CO_WAIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= CO_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      unit_q <= '0;
    end else if (cnt_en) begin
      pre_q  <= pre_d;
      unit_q <= unit_d;
    end
  end

  assign irq_o = (st_q == CO_FIRE);

  p_zero_intv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && pend_i && (intv_i == '0)) |=> irq_o);

  p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_i |=> !irq_o);

  p_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == CO_WAIT) && !hp_i && (unit_q < intv_i)) |=> !irq_o);

endmodule

// File: rtl/irq_coalescing_ctrl.sv
module irq_coalescing_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned CW          = 8,
  parameter int unsigned TICK_CYCLES = 6400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] main_evt_i,
  input  logic [31:0] flow_evt_i,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_sel_i,
  input  logic [31:0] wr_data_i,
  input  logic [1:0]  rd_sel_i,
  output logic [31:0] rd_data_o,
  output logic        irq_o
);

  logic             wr_main, wr_mask, wr_flow, wr_intv;
  logic [REG_W-1:0] main_clr, flow_clr, main_q, flow_q, sum_vec, main_view;
  logic [REG_W-1:0] mask_q;
  logic [CW-1:0]    intv_q;
  logic             pend, hp;

  always_comb begin
    wr_main = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_MAIN);
    wr_mask = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_MASK);
    wr_flow = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_FLOW);
    wr_intv = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_INTV);
  end

  // summary bits and their group clears
  always_comb begin
    sum_vec  = '0;
    main_clr = wr_main ? wr_data_i : '0;
    flow_clr = wr_flow ? wr_data_i : '0;
    for (int unsigned g = 0; g < NUM_GRP; g++) begin
      sum_vec[grp_pos(g)] = |(flow_q & grp_mask(g));
      if (wr_main && wr_data_i[grp_pos(g)]) flow_clr = flow_clr | grp_mask(g);
    end
  end

  irqc_w1c_reg #(.W(REG_W), .IMPL(MAIN_DIRECT_BITS)) u_main (
    .clk(clk), .rst_n(rst_n), .set_i(main_evt_i), .clr_i(main_clr), .q_o(main_q)
  );

  irqc_w1c_reg #(.W(REG_W), .IMPL(FLOW_IMPL_BITS)) u_flow (
    .clk(clk), .rst_n(rst_n), .set_i(flow_evt_i), .clr_i(flow_clr), .q_o(flow_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= MASK_RESET_VAL;
    else if (wr_mask) mask_q <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       intv_q <= '0;
    else if (wr_intv) intv_q <= wr_data_i[CW-1:0];
  end

  always_comb begin
    main_view = main_q | sum_vec;
    pend      = |(main_view & mask_q);
    hp        = flow_q[HP_FLOW_POS] & mask_q[HP_MASK_POS];
  end

  irqc_coalesce #(.CW(CW), .TICK_CYCLES(TICK_CYCLES)) u_coal (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .hp_i(hp), .intv_i(intv_q), .irq_o(irq_o)
  );

  always_comb begin
    unique case (reg_sel_e'(rd_sel_i))
      SEL_MAIN: rd_data_o = main_view;
      SEL_MASK: rd_data_o = mask_q;
      SEL_FLOW: rd_data_o = flow_q;
      default:  rd_data_o = REG_W'(intv_q);
    endcase
  end

  p_hp_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hp && !irq_o) |=> irq_o);

  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((main_view & mask_q) == '0) |=> !irq_o);

  p_summary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_q[16] || flow_q[17] || flow_q[30]) |-> main_view[31]);

endmodule

// File: tb/tb_irq_coalescing_ctrl.sv
module tb_irq_coalescing_ctrl;

  localparam int TICK = 4;
  localparam int CWB  = 8;

  logic        clk, rst_n, wr_en, irq;
  logic [31:0] main_evt, flow_evt, wr_data, rd_data;
  logic [1:0]  wr_sel, rd_sel;

  int checks = 0, fails = 0;
  bit done = 0;

  irq_coalescing_ctrl #(.CW(CWB), .TICK_CYCLES(TICK)) dut (
    .clk(clk), .rst_n(rst_n), .main_evt_i(main_evt), .flow_evt_i(flow_evt),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .irq_o(irq)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // {main event, flow event, expected main read, expected flow read}
  localparam logic [127:0] VEC [0:7] = '{
    {32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 32'h0000_0000},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'h1600_00CB, 32'h0000_0000},
    {32'h0000_0000, 32'h0001_0000, 32'h8000_0000, 32'h0001_0000},
    {32'h0000_0000, 32'h0002_0000, 32'h8000_0000, 32'h0002_0000},
    {32'h0000_0000, 32'h4000_0000, 32'h8000_0000, 32'h4000_0000},
    {32'h0000_0000, 32'h8000_0000, 32'h2000_0000, 32'h8000_0000},
    {32'h0000_0000, 32'h0000_0002, 32'h0800_0000, 32'h0000_0002},
    {32'h1000_0000, 32'hFFFF_FFFF, 32'hB800_0000, 32'hC003_0003}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    rd_sel = sel;
    #1 v = rd_data;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  task automatic pulse(input logic [31:0] m, input logic [31:0] f);
    @(negedge clk); main_evt = m; flow_evt = f;
    @(negedge clk); main_evt = '0; flow_evt = '0;
  endtask

  task automatic measure(input logic [31:0] m, input logic [31:0] f, input int at2,
                         input logic [31:0] m2, input logic [31:0] f2, output int n);
    @(negedge clk); main_evt = m; flow_evt = f;
    @(negedge clk); main_evt = '0; flow_evt = '0;
    n = 0;
    while (!irq && n < 300) begin
      if (n == at2) begin main_evt = m2; flow_evt = f2; end
      @(negedge clk);
      main_evt = '0; flow_evt = '0;
      n++;
    end
  endtask

  task automatic clear_all();
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd2, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    main_evt = 0; flow_evt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 main", v, 32'h0);
    rd(2'd2, v); chk("R1 flow", v, 32'h0);
    rd(2'd1, v); chk("R1 mask", v, 32'hAA00_008B);
    rd(2'd3, v); chk("R1 intv", v, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R4 / R5 vector walk
    for (int i = 0; i < 8; i++) begin
      pulse(VEC[i][127:96], VEC[i][95:64]);
      rd(2'd0, v); chk($sformatf("R4 R5 vec%0d main", i), v, VEC[i][63:32]);
      rd(2'd2, v); chk($sformatf("R4 R5 vec%0d flow", i), v, VEC[i][31:0]);
      clear_all();
    end
    rd(2'd0, v); chk("R2 cleared main", v, 32'h0);
    rd(2'd2, v); chk("R2 cleared flow", v, 32'h0);

    // R2 write 0 no effect, write 1 clears
    pulse(32'h0000_0040, 32'h0);
    wr(2'd0, 32'h0);
    rd(2'd0, v); chk("R2 write0 keeps", v, 32'h0000_0040);
    wr(2'd0, 32'h0000_0040);
    rd(2'd0, v); chk("R2 write1 clears", v, 32'h0);

    // R3 event and clear collide
    @(negedge clk);
    main_evt = 32'h1; wr_en = 1; wr_sel = 2'd0; wr_data = 32'h1;
    @(negedge clk);
    main_evt = 0; wr_en = 0; wr_data = 0;
    rd(2'd0, v); chk("R3 collide", v, 32'h1);
    clear_all();

    // R4 group clear through main register
    pulse(32'h0, 32'h8003_0000);
    wr(2'd0, 32'h8000_0000);
    rd(2'd2, v); chk("R4 group clear flow", v, 32'h8000_0000);
    rd(2'd0, v); chk("R4 group clear main", v, 32'h2000_0000);
    wr(2'd0, 32'h2000_0000);
    rd(2'd2, v); chk("R4 error group clear", v, 32'h0);

    // R5 unimplemented main bit
    pulse(32'h0000_0004, 32'h0);
    rd(2'd0, v); chk("R5 bit2 ignored", v, 32'h0);
    chk("R5 irq quiet", {31'h0, irq}, 32'h0);

    // R6 masked bit then enable
    pulse(32'h0000_0040, 32'h0);
    repeat (3) @(negedge clk);
    chk("R6 masked quiet", {31'h0, irq}, 32'h0);
    wr(2'd1, 32'hAA00_00CB);
    @(negedge clk);
    chk("R6 enable raises", {31'h0, irq}, 32'h1);
    wr(2'd1, 32'hAA00_008B);
    clear_all();
    @(negedge clk);

    // R7 zero interval latency, then R10 drop
    measure(32'h1, 32'h0, -1, 32'h0, 32'h0, n);
    chk("R7 latency", n, 1);
    @(negedge clk); wr_en = 1; wr_sel = 2'd0; wr_data = 32'h1;
    @(negedge clk); wr_en = 0; wr_data = 0;
    chk("R10 still high at clear edge", {31'h0, irq}, 32'h1);
    @(negedge clk);
    chk("R10 drops", {31'h0, irq}, 32'h0);

    // R8 interval 3
    wr(2'd3, 32'd3);
    rd(2'd3, v); chk("R1 intv readback", v, 32'd3);
    measure(32'h1, 32'h0, -1, 32'h0, 32'h0, n);
    chk("R8 latency N=3", n, 3 * TICK + 2);
    clear_all();
    @(negedge clk);
    measure(32'h1, 32'h0, 5, 32'h2, 32'h0, n);
    chk("R8 no restart", n, 3 * TICK + 2);
    clear_all();
    @(negedge clk);

    // R9 high priority bypass
    wr(2'd3, 32'd5);
    measure(32'h1, 32'h0, 4, 32'h0, 32'h4000_0000, n);
    chk("R9 bypass mid wait", n, 6);
    clear_all();
    @(negedge clk);
    chk("R10 low after clear", {31'h0, irq}, 32'h0);
    measure(32'h0, 32'h4000_0000, -1, 32'h0, 32'h0, n);
    chk("R9 bypass from idle", n, 1);
    clear_all();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule